// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks and oscillators of a small chip run in each power state. Besides normal run there are three low-power states: idle, standby and halt. Software in run mode names a target state through a request strobe and a two-bit mode field. The block then drives enables for the CPU clock, one enable per peripheral clock, the PLL, each internal oscillator and the crystal oscillator. Clock switching cells, PLL locking and oscillator start-up are outside the block. They appear only as these enable outputs and as a single oscillator-ready input.

Each low-power state keeps its own set of clocks alive and accepts its own set of wake sources. Idle stops only the CPU clock and leaves running the peripherals that software enabled. Standby stops the CPU and every peripheral but keeps the oscillators and the PLL up. Halt also stops the PLL and the crystal, and it stops each internal oscillator unless that oscillator's keep-alive bit is set. Standby and halt are entered only when the CPU and the watchdog run from the same clock source. When the block leaves halt, it restarts the oscillators first and waits for them to be ready before it restores the CPU and peripheral clocks.

Top module: `lpm_clkctl`

## Requirements
- R1: After reset the block is in run: mode code 00, CPU, peripheral, PLL, internal-oscillator and crystal enables all 1, wake cause 0 and error flag 0.
- R2: A request with mode field 01 in run enters idle on the next edge. Idle shows mode code 01 and CPU enable 0. Each peripheral enable follows that peripheral's run-enable bit. PLL, oscillators and crystal stay at 1.
- R3: Idle returns to run on the edge after a peripheral interrupt whose run-enable bit is set (cause 1) or after a watchdog wake (cause 2). The peripheral interrupt wins when both occur. Interrupts of disabled peripherals, external interrupt and GPIO wake are ignored in idle.
- R4: A request with mode field 10 in run, with matching CPU and watchdog sources, enters standby. Standby shows mode code 10, CPU and all peripheral enables 0, and PLL, oscillators and crystal at 1.
- R5: Standby returns to run only on the edge after an external interrupt, with cause 3. The CPU enable is 1 in the cycle after that edge. Peripheral interrupts, watchdog and GPIO wake are ignored in standby.
- R6: A request with mode field 11 in run, with matching sources, enters halt. Halt shows mode code 11 and CPU, peripheral, PLL and crystal enables 0. Each internal-oscillator enable equals its keep-alive bit as sampled in the request cycle. Later changes to the keep-alive bits have no effect.
- R7: Halt is left on a GPIO wake (cause 4) or a watchdog wake (cause 2), with GPIO winning. The block first enters a resume phase: mode code stays 11, PLL, all oscillators and crystal are 1, and CPU and peripherals are 0. The phase lasts until the edge on which oscillator-ready is 1, and the block is in run after that edge. External interrupt is ignored in halt.
- R8: A standby or halt request whose CPU source differs from its watchdog source is refused. The block stays in run and sets the error flag. The flag holds until the next accepted request clears it.
- R9: Requests with mode field 00, and any request made outside run, change nothing.
- R10: Asserting the active-low reset returns the block to the R1 state at once from any state, without waiting for a clock edge.
- R11: The wake cause code (0 none, 1 peripheral, 2 watchdog, 3 external interrupt, 4 GPIO) holds its value until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 00 none, 01 idle, 10 standby, 11 halt |
| periph_run_en | input | NPER | Per-peripheral enable to keep running in idle |
| osc_keep | input | NOSC | Per-internal-oscillator keep-alive in halt |
| cpu_src | input | SRCW | CPU clock source selector |
| wd_src | input | SRCW | Watchdog clock source selector |
| irq | input | NPER | Peripheral interrupt lines |
| wdog_wake | input | 1 | Watchdog wake event |
| ext_irq | input | 1 | External interrupt event |
| gpio_wake | input | 1 | GPIO wake event |
| osc_ready | input | 1 | Oscillators stable after restart |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NPER | Peripheral clock enables |
| pll_en | output | 1 | PLL enable |
| intosc_en | output | NOSC | Internal oscillator enables |
| xtal_en | output | 1 | Crystal oscillator enable |
| mode_code | output | 2 | Current mode: 00 run, 01 idle, 10 standby, 11 halt |
| wake_cause | output | 3 | Cause of last wake |
| entry_err | output | 1 | Sticky refused-entry flag |

## Verification
The bench builds the block with six peripherals, three internal oscillators and two-bit source selectors. This exercises the per-bit masking of interrupts by run-enable bits and lets keep-alive patterns with set and cleared bits side by side be told apart in halt. With two-bit selectors, the bench can pick matching and mismatching source pairs in every state. Random stimulus therefore covers refused entries, wakes that arrive together and long resume waits, in addition to the directed cases.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_STBY   = 3'd2,
    ST_HALT   = 3'd3,
    ST_RESUME = 3'd4
  } lpm_state_e;

  localparam logic [1:0] MC_RUN  = 2'b00;
  localparam logic [1:0] MC_IDLE = 2'b01;
  localparam logic [1:0] MC_STBY = 2'b10;
  localparam logic [1:0] MC_HALT = 2'b11;

  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] WK_NONE   = 3'd0;
  localparam logic [CAUSE_W-1:0] WK_PERIPH = 3'd1;
  localparam logic [CAUSE_W-1:0] WK_WDOG   = 3'd2;
  localparam logic [CAUSE_W-1:0] WK_EXT    = 3'd3;
  localparam logic [CAUSE_W-1:0] WK_GPIO   = 3'd4;
endpackage

// File: rtl/lpm_wake_sel.sv
`timescale 1ns/1ps
module lpm_wake_sel
  import lpm_pkg::*;
#(
  parameter int NPER = 4
) (
  input  lpm_state_e           state,
  input  logic [NPER-1:0]      irq,
  input  logic [NPER-1:0]      run_en,
  input  logic                 wdog_wake,
  input  logic                 ext_irq,
  input  logic                 gpio_wake,
  output logic                 hit,
  output logic [CAUSE_W-1:0]   code
);
  logic periph_hit;
  assign periph_hit = |(irq & run_en);

  always_comb begin
    hit  = 1'b0;
    code = WK_NONE;
    case (state)
      ST_IDLE: begin
        if (periph_hit) begin
          hit  = 1'b1;
          code = WK_PERIPH;
        end else if (wdog_wake) begin
          hit  = 1'b1;
          code = WK_WDOG;
        end
      end
      ST_STBY: begin
        if (ext_irq) begin
          hit  = 1'b1;
          code = WK_EXT;
        end
      end
      ST_HALT: begin
        if (gpio_wake) begin
          hit  = 1'b1;
          code = WK_GPIO;
        end else if (wdog_wake) begin
          hit  = 1'b1;
          code = WK_WDOG;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_gate_map.sv
`timescale 1ns/1ps
module lpm_gate_map
  import lpm_pkg::*;
#(
  parameter int NPER = 4,
  parameter int NOSC = 2
) (
  input  lpm_state_e      state,
  input  logic [NPER-1:0] run_en,
  input  logic [NOSC-1:0] keep,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en,
  output logic            pll_en,
  output logic [NOSC-1:0] osc_en,
  output logic            xtal_en,
  output logic [1:0]      mode_code
);
  logic in_run, in_idle, in_halt;
  assign in_run  = (state == ST_RUN);
  assign in_idle = (state == ST_IDLE);
  assign in_halt = (state == ST_HALT);

  assign cpu_en  = in_run;
  assign pll_en  = !in_halt;
  assign xtal_en = !in_halt;

  for (genvar g = 0; g < NPER; g++) begin : g_per
    assign per_en[g] = in_run || (in_idle && run_en[g]);
  end

  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    assign osc_en[g] = !in_halt || keep[g];
  end

  always_comb begin
    case (state)
      ST_IDLE:   mode_code = MC_IDLE;
      ST_STBY:   mode_code = MC_STBY;
      ST_HALT,
      ST_RESUME: mode_code = MC_HALT;
      default:   mode_code = MC_RUN;
    endcase
  end
endmodule

// File: rtl/lpm_clkctl.sv
`timescale 1ns/1ps
module lpm_clkctl
  import lpm_pkg::*;
#(
  parameter int NPER = 4,
  parameter int NOSC = 2,
  parameter int SRCW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic [NPER-1:0]     periph_run_en,
  input  logic [NOSC-1:0]     osc_keep,
  input  logic [SRCW-1:0]     cpu_src,
  input  logic [SRCW-1:0]     wd_src,
  input  logic [NPER-1:0]     irq,
  input  logic                wdog_wake,
  input  logic                ext_irq,
  input  logic                gpio_wake,
  input  logic                osc_ready,
  output logic                cpu_clk_en,
  output logic [NPER-1:0]     periph_clk_en,
  output logic                pll_en,
  output logic [NOSC-1:0]     intosc_en,
  output logic                xtal_en,
  output logic [1:0]          mode_code,
  output logic [CAUSE_W-1:0]  wake_cause,
  output logic                entry_err
);
  lpm_state_e          state_q, state_d;
  logic                err_q, err_d;
  logic [CAUSE_W-1:0]  cause_q;
  logic [NOSC-1:0]     keep_q;
  logic                keep_ld;
  logic                wake_hit;
  logic [CAUSE_W-1:0]  wake_code;
  logic                src_match;

  assign src_match = (cpu_src == wd_src);

  lpm_wake_sel #(.NPER(NPER)) i_wake (
    .state     (state_q),
    .irq       (irq),
    .run_en    (periph_run_en),
    .wdog_wake (wdog_wake),
    .ext_irq   (ext_irq),
    .gpio_wake (gpio_wake),
    .hit       (wake_hit),
    .code      (wake_code)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    keep_ld = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (req_valid) begin
          if (req_mode == MC_IDLE) begin
            state_d = ST_IDLE;
            err_d   = 1'b0;
          end else if (req_mode == MC_STBY || req_mode == MC_HALT) begin
            if (src_match) begin
              state_d = (req_mode == MC_HALT) ? ST_HALT : ST_STBY;
              err_d   = 1'b0;
              keep_ld = (req_mode == MC_HALT);
            end else begin
              err_d = 1'b1;
            end
          end
        end
      end
      ST_IDLE, ST_STBY: if (wake_hit) state_d = ST_RUN;
      ST_HALT:          if (wake_hit) state_d = ST_RESUME;
      ST_RESUME:        if (osc_ready) state_d = ST_RUN;
      default:          state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      err_q   <= 1'b0;
      cause_q <= WK_NONE;
      keep_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (wake_hit) cause_q <= wake_code;
      if (keep_ld)  keep_q  <= osc_keep;
    end
  end

  lpm_gate_map #(.NPER(NPER), .NOSC(NOSC)) i_map (
    .state     (state_q),
    .run_en    (periph_run_en),
    .keep      (keep_q),
    .cpu_en    (cpu_clk_en),
    .per_en    (periph_clk_en),
    .pll_en    (pll_en),
    .osc_en    (intosc_en),
    .xtal_en   (xtal_en),
    .mode_code (mode_code)
  );

  assign wake_cause = cause_q;
  assign entry_err  = err_q;
endmodule

// File: rtl/lpm_clkctl_chk.sv
`timescale 1ns/1ps
module lpm_clkctl_chk #(
  parameter int NPER = 4,
  parameter int NOSC = 2,
  parameter int SRCW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_mode,
  input logic [NPER-1:0] periph_run_en,
  input logic [SRCW-1:0] cpu_src,
  input logic [SRCW-1:0] wd_src,
  input logic [NPER-1:0] irq,
  input logic            wdog_wake,
  input logic            ext_irq,
  input logic            osc_ready,
  input logic            cpu_clk_en,
  input logic [NPER-1:0] periph_clk_en,
  input logic            pll_en,
  input logic            xtal_en,
  input logic [1:0]      mode_code,
  input logic            entry_err
);
  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01) |-> (!cpu_clk_en && periph_clk_en == periph_run_en && pll_en && xtal_en));

  // R3
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01 && ((irq & periph_run_en) != '0 || wdog_wake)) |=> (mode_code == 2'b00));

  // R5
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b10 && !ext_irq) |=> (mode_code == 2'b10 && !cpu_clk_en));

  // R6
  halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11 && !pll_en) |-> (!xtal_en && !cpu_clk_en && periph_clk_en == '0));

  // R7
  resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11 && pll_en && !osc_ready) |=> (mode_code == 2'b11 && !cpu_clk_en));

  // R8
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00 && req_valid && req_mode[1] && cpu_src != wd_src) |=> (mode_code == 2'b00 && entry_err));
endmodule

bind lpm_clkctl lpm_clkctl_chk #(.NPER(NPER), .NOSC(NOSC), .SRCW(SRCW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_mode      (req_mode),
  .periph_run_en (periph_run_en),
  .cpu_src       (cpu_src),
  .wd_src        (wd_src),
  .irq           (irq),
  .wdog_wake     (wdog_wake),
  .ext_irq       (ext_irq),
  .osc_ready     (osc_ready),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_en        (pll_en),
  .xtal_en       (xtal_en),
  .mode_code     (mode_code),
  .entry_err     (entry_err)
);

// File: tb/test_lpm_clkctl.sv
`timescale 1ns/1ps
module test_lpm_clkctl;
  localparam int NPER = 6;
  localparam int NOSC = 3;
  localparam int SRCW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_mode;
  logic [NPER-1:0] periph_run_en, irq;
  logic [NOSC-1:0] osc_keep;
  logic [SRCW-1:0] cpu_src, wd_src;
  logic wdog_wake, ext_irq, gpio_wake, osc_ready;
  logic cpu_clk_en, pll_en, xtal_en, entry_err;
  logic [NPER-1:0] periph_clk_en;
  logic [NOSC-1:0] intosc_en;
  logic [1:0] mode_code;
  logic [2:0] wake_cause;

  int n_chk = 0;
  int n_bad = 0;

  // bench model: 0 run, 1 idle, 2 standby, 3 halt, 4 resume
  int m_st, m_st_n;
  logic m_err, m_err_n;
  logic [2:0] m_cause, m_cause_n;
  logic [NOSC-1:0] m_keep, m_keep_n;

  always #2.5 clk = ~clk;

  lpm_clkctl #(.NPER(NPER), .NOSC(NOSC), .SRCW(SRCW)) i_lpm_clkctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .periph_run_en(periph_run_en), .osc_keep(osc_keep), .cpu_src(cpu_src),
    .wd_src(wd_src), .irq(irq), .wdog_wake(wdog_wake), .ext_irq(ext_irq),
    .gpio_wake(gpio_wake), .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .pll_en(pll_en), .intosc_en(intosc_en),
    .xtal_en(xtal_en), .mode_code(mode_code), .wake_cause(wake_cause),
    .entry_err(entry_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input int st);
    return (st == 4) ? 2'b11 : st[1:0];
  endfunction

  task automatic compare_all(input string tag);
    logic [NPER-1:0] ep;
    ep = (m_st == 0) ? '1 : (m_st == 1) ? periph_run_en : '0;
    chk(tag, "mode", 32'(mode_code), 32'(exp_mode(m_st)));
    chk(tag, "cpu", 32'(cpu_clk_en), 32'(m_st == 0));
    chk(tag, "periph", 32'(periph_clk_en), 32'(ep));
    chk(tag, "pll", 32'(pll_en), 32'(m_st != 3));
    chk(tag, "xtal", 32'(xtal_en), 32'(m_st != 3));
    chk(tag, "osc", 32'(intosc_en), 32'((m_st == 3) ? m_keep : {NOSC{1'b1}}));
    chk(tag, "cause", 32'(wake_cause), 32'(m_cause));
    chk(tag, "err", 32'(entry_err), 32'(m_err));
  endtask

  task automatic model_next();
    m_st_n = m_st; m_err_n = m_err; m_cause_n = m_cause; m_keep_n = m_keep;
    case (m_st)
      0: if (req_valid) begin
           if (req_mode == 2'b01) begin m_st_n = 1; m_err_n = 1'b0; end
           else if (req_mode[1]) begin
             if (cpu_src == wd_src) begin
               m_st_n = int'(req_mode); m_err_n = 1'b0;
               if (req_mode == 2'b11) m_keep_n = osc_keep;
             end else m_err_n = 1'b1;
           end
         end
      1: if ((irq & periph_run_en) != '0) begin m_st_n = 0; m_cause_n = 3'd1; end
         else if (wdog_wake) begin m_st_n = 0; m_cause_n = 3'd2; end
      2: if (ext_irq) begin m_st_n = 0; m_cause_n = 3'd3; end
      3: if (gpio_wake) begin m_st_n = 4; m_cause_n = 3'd4; end
         else if (wdog_wake) begin m_st_n = 4; m_cause_n = 3'd2; end
      default: if (osc_ready) m_st_n = 0;
    endcase
  endtask

  task automatic cyc(input string tag);
    model_next();
    @(posedge clk); #1;
    m_st = m_st_n; m_err = m_err_n; m_cause = m_cause_n; m_keep = m_keep_n;
    compare_all(tag);
  endtask

  task automatic quiet();
    req_valid = 1'b0; req_mode = 2'b00; irq = '0;
    wdog_wake = 1'b0; ext_irq = 1'b0; gpio_wake = 1'b0; osc_ready = 1'b0;
  endtask

  task automatic model_reset();
    m_st = 0; m_err = 1'b0; m_cause = 3'd0; m_keep = '0;
  endtask

  task automatic request(input logic [1:0] md);
    req_valid = 1'b1; req_mode = md;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    periph_run_en = '0; osc_keep = '0; cpu_src = 2'd1; wd_src = 2'd1;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 compare_all("R1");

    // R9: mode field 00 does nothing
    request(2'b00); cyc("R9");
    quiet();

    // R2 and R3: idle entry and masked wake
    periph_run_en = 6'b100101;
    request(2'b01); cyc("R2");
    quiet(); irq = 6'b010010; ext_irq = 1'b1; gpio_wake = 1'b1;
    request(2'b11); cyc("R3");
    chk("R9", "stay idle on request", 32'(mode_code), 32'h1);
    quiet(); irq = 6'b000100; wdog_wake = 1'b1; cyc("R3");
    chk("R11", "periph cause", 32'(wake_cause), 32'h1);

    // R8: refused entry, cleared by next accepted request
    quiet(); cpu_src = 2'd1; wd_src = 2'd2;
    request(2'b11); cyc("R8");
    chk("R8", "err set", 32'(entry_err), 32'h1);
    quiet(); cyc("R8");
    request(2'b01); cyc("R8");
    quiet(); wdog_wake = 1'b1; cyc("R3");
    chk("R11", "wdog cause", 32'(wake_cause), 32'h2);

    // R4 and R5: standby
    quiet(); wd_src = 2'd1;
    request(2'b10); cyc("R4");
    quiet(); irq = '1; periph_run_en = '1; wdog_wake = 1'b1; gpio_wake = 1'b1; cyc("R5");
    quiet(); cyc("R5");
    ext_irq = 1'b1; cyc("R5");
    chk("R5", "cpu back", 32'(cpu_clk_en), 32'h1);

    // R6 and R7: halt with keep-alive and resume
    quiet(); osc_keep = 3'b010;
    request(2'b11); cyc("R6");
    quiet(); osc_keep = 3'b101; cyc("R6");
    ext_irq = 1'b1; cyc("R7");
    quiet(); gpio_wake = 1'b1; wdog_wake = 1'b1; cyc("R7");
    chk("R7", "gpio cause", 32'(wake_cause), 32'h4);
    quiet(); cyc("R7"); cyc("R7");
    osc_ready = 1'b1; cyc("R7");
    quiet(); cyc("R11");

    // R10: asynchronous reset from halt
    request(2'b11); cyc("R6");
    quiet(); cyc("R6");
    #1 rst_n = 1'b0;
    model_reset();
    #1 compare_all("R10");
    @(negedge clk); rst_n = 1'b1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      string tag;
      quiet();
      req_valid = ($urandom % 4) == 0;
      req_mode = 2'($urandom);
      for (int b = 0; b < NPER; b++) irq[b] = ($urandom % 16) == 0;
      if (($urandom % 32) == 0) periph_run_en = NPER'($urandom);
      osc_keep = NOSC'($urandom);
      cpu_src = 2'($urandom);
      wd_src = (($urandom % 4) != 0) ? cpu_src : 2'($urandom);
      wdog_wake = ($urandom % 20) == 0;
      ext_irq = ($urandom % 12) == 0;
      gpio_wake = ($urandom % 12) == 0;
      osc_ready = ($urandom % 4) == 0;
      case (m_st)
        0: tag = "R8";
        1: tag = "R3";
        2: tag = "R5";
        3: tag = "R6";
        default: tag = "R7";
      endcase
      cyc(tag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule